// File: doc/BRIEF.md
# Serial Jump Target Loader

This block sits beside one port of a line-organised frame store and assembles that port's jump destination from a single serial address pin. The host drops a setup strobe while the port's pointer-reset input stays high. From that clock edge on, one address bit arrives per clock, most significant first. Releasing the strobe early stops the transfer, and every lower bit position that was not sent keeps its earlier value. This lets a host reload only the line part of a destination and step through a frame at a fixed stride.

Once loading begins, a settling interval of 64 clocks must run before the new destination may be used. The block reports this with a busy flag while the interval runs and a ready flag once it has elapsed. A jump command is both the strobe and the pointer-reset input low together. The block watches for it and raises a one-cycle violation pulse when the jump comes too early or points at a location that cannot be a jump destination. The block does not move any pointer and does not touch memory.

Top module: `jump_target_loader`

## Requirements
- R1: After reset, ready, busy and violation are low and both target fields read zero.
- R2: A load starts at the rising clock edge that sees the strobe low, the strobe high at the previous edge, and the pointer-reset input high. That edge captures the most significant bit, and each later edge with the strobe still low captures the next lower bit.
- R3: The mode code selects the target layout. 2'b10 gives a 15-bit target: a 9-bit line field then a 6-bit horizontal field. 2'b01 and the linear codes 2'b00 and 2'b11 give a 14-bit target, shown as a 9-bit line field then a 5-bit horizontal field, where the horizontal output's top bit reads 0.
- R4: When the strobe returns high before the last bit, the bit positions not yet sent keep their previous values.
- R5: A load start clears ready and sets busy in the same edge. The 64th edge after the start edge sets ready and clears busy. Ready and busy are never high together.
- R6: A strobe fall while the pointer-reset input is low starts no load and leaves the target and busy unchanged.
- R7: A jump command is the edge at which the strobe and the pointer-reset input are both low after not both being low at the previous edge. If ready is low at that edge, violation is high for exactly the next cycle.
- R8: A jump command also raises violation if the whole target is zero. It does the same in mode 2'b01 if the horizontal field is 31, and in mode 2'b10 if it is 35 or more.
- R9: A jump command made when ready is high and the target is legal leaves violation low.
- R10: Holding the strobe low after the last bit has been captured changes no further bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe_n | input | 1 | Address setup strobe, active low |
| ptr_rst_n | input | 1 | Port pointer-reset input, active low |
| addr_bit | input | 1 | Serial address bit |
| mode | input | 2 | Addressing layout code |
| line_f | output | 9 | Line field of the target |
| horiz_f | output | 6 | Horizontal field of the target |
| ready | output | 1 | Target settled, jumps allowed |
| busy | output | 1 | Settling interval running |
| violation | output | 1 | One-cycle pulse for an illegal jump |

## Verification
The assertions assume that the mode code stays fixed while bits are being shifted in and during the settling interval after a load. They also assume that a jump command is never issued in the same cycle as a strobe that is still shifting. The bench changes the mode only while the block is idle between loads. It places every jump at least two cycles after the strobe has gone high again. This keeps a strobe that is still low from turning into a jump edge.

// File: rtl/jump_target_loader.sv
module jump_target_loader #(
  parameter int LINE_W = 9,
  parameter int H_W    = 6,
  parameter int SETTLE = 64,
  parameter int H_END_N = 31,
  parameter int H_END_W = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_n,
  input  logic              ptr_rst_n,
  input  logic              addr_bit,
  input  logic [1:0]        mode,
  output logic [LINE_W-1:0] line_f,
  output logic [H_W-1:0]    horiz_f,
  output logic              ready,
  output logic              busy,
  output logic              violation
);
  localparam int TW = LINE_W + H_W;
  localparam int IW = $clog2(TW);
  localparam int CW = $clog2(SETTLE + 1);

  logic [TW-1:0] tgt;
  logic [IW-1:0] idx, top_idx;
  logic [CW-1:0] cnt;
  logic          active, strobe_q, prst_q, wide, start, jump, illegal;

  assign wide    = (mode == 2'b10);
  assign top_idx = wide ? IW'(TW - 1) : IW'(TW - 2);
  assign start   = ~strobe_n & strobe_q & ptr_rst_n;
  assign jump    = ~strobe_n & ~ptr_rst_n & (strobe_q | prst_q);

  assign line_f  = wide ? tgt[TW-1 -: LINE_W] : tgt[TW-2 -: LINE_W];
  assign horiz_f = wide ? tgt[H_W-1:0] : {1'b0, tgt[H_W-2:0]};
  assign illegal = (line_f == '0 && horiz_f == '0)
                 | (mode == 2'b01 && horiz_f == H_W'(H_END_N))
                 | (wide && horiz_f >= H_W'(H_END_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b1;
      prst_q   <= 1'b1;
    end else begin
      strobe_q <= strobe_n;
      prst_q   <= ptr_rst_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt    <= '0;
      idx    <= '0;
      active <= 1'b0;
    end else if (start) begin
      tgt[top_idx] <= addr_bit;
      idx          <= top_idx - 1'b1;
      active       <= 1'b1;
    end else if (active) begin
      if (strobe_n) begin
        active <= 1'b0;
      end else begin
        tgt[idx] <= addr_bit;
        if (idx == '0) active <= 1'b0;
        else           idx    <= idx - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
      busy  <= 1'b0;
    end else if (start) begin
      cnt   <= CW'(1);
      ready <= 1'b0;
      busy  <= 1'b1;
    end else if (busy) begin
      if (cnt == CW'(SETTLE)) begin
        cnt   <= '0;
        ready <= 1'b1;
        busy  <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) violation <= 1'b0;
    else        violation <= jump & (~ready | illegal);
  end

  // R5
  start_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!ready && busy));
  // R5
  ready_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && busy));
  // R4
  masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && strobe_n && ptr_rst_n && !start) |=> $stable(tgt));
  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (idx < top_idx));
  // R7
  early_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jump && !ready) |=> violation);
  // R6
  no_load_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_rst_n && !busy) |=> !busy);
endmodule

// File: tb/test_jump_target_loader.sv
module test_jump_target_loader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic strobe_n = 1'b1, ptr_rst_n = 1'b1, addr_bit = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [8:0] line_f;
  logic [5:0] horiz_f;
  logic ready, busy, violation;
  int checks = 0, failures = 0;
  logic [14:0] model = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  jump_target_loader i_jump_target_loader (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .ptr_rst_n(ptr_rst_n),
    .addr_bit(addr_bit), .mode(mode), .line_f(line_f), .horiz_f(horiz_f),
    .ready(ready), .busy(busy), .violation(violation));

  function automatic logic [8:0] exp_line(input logic [1:0] m, input logic [14:0] t);
    return (m == 2'b10) ? t[14:6] : t[13:5];
  endfunction
  function automatic logic [5:0] exp_horiz(input logic [1:0] m, input logic [14:0] t);
    return (m == 2'b10) ? t[5:0] : {1'b0, t[4:0]};
  endfunction
  function automatic bit exp_illegal(input logic [1:0] m, input logic [14:0] t);
    logic [5:0] h = exp_horiz(m, t);
    return (exp_line(m, t) == 0 && h == 0) || (m == 2'b01 && h == 31)
        || (m == 2'b10 && h >= 35);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_load(input logic [1:0] m, input logic [14:0] v,
                          input int nsend, input int jat);
    int w = (m == 2'b10) ? 15 : 14;
    mode = m;
    for (int i = 0; i <= 66; i++) begin
      strobe_n  = !(i < nsend);
      addr_bit  = (i < nsend && i < w) ? v[w-1-i] : 1'($urandom);
      ptr_rst_n = 1'b1;
      if (jat > 0 && i == jat) begin strobe_n = 1'b0; ptr_rst_n = 1'b0; end
      if (i < nsend && i < w) model[w-1-i] = v[w-1-i];
      @(posedge clk); @(negedge clk);
      if (i == 0) check(busy && !ready, "R5 start", {busy, ready}, 2'b10);
      if (i == 63) check(!ready, "R5 early", ready, 0);
      if (i == 64) check(ready && !busy, "R5 settle", {busy, ready}, 2'b01);
      if (jat > 0 && i == jat) check(violation, "R7 early jump", violation, 1);
    end
    strobe_n = 1'b1; ptr_rst_n = 1'b1;
    check(line_f == exp_line(m, model), "R2 R3 R4 R10 line", line_f, exp_line(m, model));
    check(horiz_f == exp_horiz(m, model), "R2 R3 R4 R10 horiz", horiz_f, exp_horiz(m, model));
  endtask

  task automatic do_jump(input bit expv, input string tag);
    strobe_n = 1'b0; ptr_rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check(violation == expv, tag, violation, expv);
    strobe_n = 1'b1; ptr_rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(!violation, "R7 pulse width", violation, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog act=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ready && !busy && !violation, "R1 flags", {ready, busy, violation}, 0);
    check(line_f == 0 && horiz_f == 0, "R1 target", {line_f, horiz_f}, 0);
    do_jump(1'b1, "R7 jump before any load");
    check(!busy && line_f == 0 && horiz_f == 0, "R6 no load", {busy, line_f, horiz_f}, 0);
    // full wide load, legal
    run_load(2'b10, 15'h1A45, 15, 0);
    do_jump(exp_illegal(2'b10, model), "R9 legal jump");
    // line-only reload keeps horizontal field
    run_load(2'b10, 15'h7FFF, 9, 12);
    check(horiz_f == exp_horiz(2'b10, 15'h1A45), "R4 masked", horiz_f, 6'h05);
    // oversend in 14-bit mode
    run_load(2'b01, 15'h155F, 18, 0);
    do_jump(1'b1, "R8 line end 31");
    run_load(2'b10, 15'h0023, 15, 0);
    do_jump(1'b1, "R8 horiz 35");
    run_load(2'b00, 15'h0000, 14, 0);
    do_jump(1'b1, "R8 zero target");
    run_load(2'b11, 15'h0001, 1, 0);
    do_jump(exp_illegal(2'b11, model), "R9 R3 one bit");
    for (int k = 0; k < 30; k++) begin
      logic [1:0] m = 2'($urandom);
      logic [14:0] v = 15'($urandom);
      int ns = 1 + int'($urandom % 17);
      int ja = ($urandom % 3 == 0) ? ns + 2 : 0;
      run_load(m, v, ns, ja);
      do_jump(exp_illegal(m, model), "R8 R9 random jump");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule